// File: doc/BRIEF.md
# Gray-Coded PAM4 Transmit Feed-Forward Equalizer

This block turns a serial stream of data bits into equalized four-level amplitude codes for a transmit DAC. Bits arrive one per accepted cycle with a valid strobe. In four-level mode each pair of bits becomes one symbol, with the earlier bit as the more significant one. The pair is mapped through a Gray table to a signed level of -3, -1, +1 or +3. In two-level mode each bit alone becomes a symbol, and the less significant bit is forced to zero, so only the two outer levels are produced.

Each symbol then passes through a three-tap feed-forward filter. The filter has a pre-cursor tap, a main tap and a post-cursor tap, each with an unsigned programmable weight. Both side taps are subtracted. Because the pre-cursor term needs the symbol that follows the current one, each output is one symbol late. The output valid stays low until three symbols have entered the filter. The output word is wide enough that every one of the 64 combinations of three levels is exact at any setting of the weights.

The weights are static configuration. They must be held steady while output codes are being produced. The block has no handshake: it produces one output code per symbol once the filter is full.

Top module: `pam4_ffe_tx`

## Requirements
- R1: In four-level mode, two consecutive accepted bits form one symbol, and the first of the two accepted bits is the MSB.
- R2: The (MSB,LSB) pair maps to a level as follows: 00 gives -3, 01 gives -1, 11 gives +1 and 10 gives +3. Neighbouring levels therefore differ in one bit.
- R3: For a centre symbol s[n], the output is main·s[n] − pre·s[n+1] − post·s[n−1]. Here s[n+1] is the symbol accepted after s[n], and s[n−1] is the one accepted before it.
- R4: When `pam2_mode` is 1, every accepted bit forms its own symbol as MSB, with the LSB forced to 0. A 1 gives +3 and a 0 gives −3.
- R5: `dac_vld` stays low until three symbols have been accepted since reset. After that it pulses once for each new symbol. The pulse comes on the clock edge after the edge that accepts the bit completing that new symbol.
- R6: The output has TAP_W+5 bits in two's complement. All 64 combinations of three levels give the exact value, with no wrap, even when all weights are at their maximum.
- R7: While `rst` is high, `dac_vld` and `dac_code` are 0 after the next clock edge, and the pairing and filter history are cleared.
- R8: Cycles with `bit_vld` low are ignored. The value on `bit_in` in those cycles does not change the result, and idle gaps, including a gap between the two bits of a pair, do not change the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | bit_in is accepted on this edge |
| pam2_mode | input | 1 | 1 selects two-level operation, 0 selects four-level operation |
| tap_pre | input | TAP_W | Unsigned pre-cursor weight, subtracted |
| tap_main | input | TAP_W | Unsigned main-cursor weight, added |
| tap_post | input | TAP_W | Unsigned post-cursor weight, subtracted |
| dac_code | output | TAP_W+5 | Signed equalized DAC code |
| dac_vld | output | 1 | dac_code holds a new value |

## Verification
A pairing register that has slipped by one bit shows up at once as a stream whose levels are all wrong from the next output on. A wrong Gray entry or a swapped tap sign shows up in the first output that uses that level or tap. A history register that is not cleared or not shifted shows up as a missing or extra `dac_vld` pulse, or as one wrong value. This appears within the first three symbols after reset. The tests use an identity weight setting to expose the mapping directly, a sweep over all 64 level combinations at maximum weights, an exact cycle check on the first valid pulse, and streams with idle gaps whose `bit_in` carries noise.

// File: rtl/pam4_ffe_pkg.sv
package pam4_ffe_pkg;

  // signed symbol level, one of -3, -1, +1, +3
  typedef logic signed [2:0] lvl_t;

  localparam int NUM_TAPS = 3;

  // Gray assignment: adjacent levels differ in a single bit
  function automatic lvl_t gray_level(input logic msb, input logic lsb);
    lvl_t v;
    unique case ({msb, lsb})
      2'b00:   v = -3'sd3;
      2'b01:   v = -3'sd1;
      2'b11:   v = 3'sd1;
      default: v = 3'sd3;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pam4_bit_pair.sv
module pam4_bit_pair #(
  parameter logic PAM2_LSB = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic pam2_mode,
  output logic sym_vld,
  output logic sym_msb,
  output logic sym_lsb
);

  logic half_q;
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      sym_vld <= 1'b0;
      sym_msb <= 1'b0;
      sym_lsb <= 1'b0;
    end else begin
      sym_vld <= 1'b0;
      if (bit_vld) begin
        if (pam2_mode) begin
          sym_vld <= 1'b1;
          sym_msb <= bit_in;
          sym_lsb <= PAM2_LSB;
          half_q  <= 1'b0;
        end else if (!half_q) begin
          first_q <= bit_in;
          half_q  <= 1'b1;
        end else begin
          sym_vld <= 1'b1;
          sym_msb <= first_q;
          sym_lsb <= bit_in;
          half_q  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pam4_gray_map.sv
module pam4_gray_map
  import pam4_ffe_pkg::*;
(
  input  logic msb,
  input  logic lsb,
  output lvl_t level
);

  always_comb level = gray_level(msb, lsb);

endmodule

// File: rtl/pam4_ffe_fir.sv
module pam4_ffe_fir
  import pam4_ffe_pkg::*;
#(
  parameter int TAP_W = 6,
  parameter int OUT_W = TAP_W + 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sym_vld,
  input  lvl_t                    sym_lvl,
  input  logic [TAP_W-1:0]        tap_pre,
  input  logic [TAP_W-1:0]        tap_main,
  input  logic [TAP_W-1:0]        tap_post,
  output logic signed [OUT_W-1:0] dac_code,
  output logic                    dac_vld
);

  localparam int FILL_W = 2;
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(NUM_TAPS - 1);

  lvl_t              cur_q;
  lvl_t              old_q;
  logic [FILL_W-1:0] fill_q;

  // index 0: newest (pre-cursor), 1: centre, 2: oldest (post-cursor)
  lvl_t                    lvl_v  [NUM_TAPS];
  logic [TAP_W-1:0]        tap_v  [NUM_TAPS];
  logic signed [OUT_W-1:0] term_v [NUM_TAPS];
  logic signed [OUT_W-1:0] acc;

  always_comb begin
    lvl_v[0] = sym_lvl;
    lvl_v[1] = cur_q;
    lvl_v[2] = old_q;
    tap_v[0] = tap_pre;
    tap_v[1] = tap_main;
    tap_v[2] = tap_post;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam bit SUBTRACT = (k != 1);
    logic signed [OUT_W-1:0] wt;
    logic signed [OUT_W-1:0] lv;
    logic signed [OUT_W-1:0] prod;
    assign wt   = $signed({{(OUT_W-TAP_W){1'b0}}, tap_v[k]});
    assign lv   = $signed({{(OUT_W-3){lvl_v[k][2]}}, lvl_v[k]});
    assign prod = wt * lv;
    if (SUBTRACT) begin : g_neg
      assign term_v[k] = -prod;
    end else begin : g_pos
      assign term_v[k] = prod;
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TAPS; k++) acc = acc + term_v[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      old_q    <= '0;
      fill_q   <= '0;
      dac_code <= '0;
      dac_vld  <= 1'b0;
    end else begin
      dac_vld <= 1'b0;
      if (sym_vld) begin
        cur_q <= sym_lvl;
        old_q <= cur_q;
        if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
        if (fill_q == FILL_FULL) begin
          dac_code <= acc;
          dac_vld  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pam4_ffe_tx.sv
module pam4_ffe_tx
  import pam4_ffe_pkg::*;
#(
  parameter int   TAP_W    = 6,
  parameter logic PAM2_LSB = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_in,
  input  logic                  bit_vld,
  input  logic                  pam2_mode,
  input  logic [TAP_W-1:0]      tap_pre,
  input  logic [TAP_W-1:0]      tap_main,
  input  logic [TAP_W-1:0]      tap_post,
  output logic signed [TAP_W+4:0] dac_code,
  output logic                  dac_vld
);

  localparam int OUT_W = TAP_W + 5;

  logic sym_vld;
  logic sym_msb;
  logic sym_lsb;
  lvl_t sym_lvl;

  pam4_bit_pair #(.PAM2_LSB(PAM2_LSB)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .bit_vld   (bit_vld),
    .pam2_mode (pam2_mode),
    .sym_vld   (sym_vld),
    .sym_msb   (sym_msb),
    .sym_lsb   (sym_lsb)
  );

  pam4_gray_map u_map (
    .msb   (sym_msb),
    .lsb   (sym_lsb),
    .level (sym_lvl)
  );

  pam4_ffe_fir #(.TAP_W(TAP_W), .OUT_W(OUT_W)) u_fir (
    .clk      (clk),
    .rst      (rst),
    .sym_vld  (sym_vld),
    .sym_lvl  (sym_lvl),
    .tap_pre  (tap_pre),
    .tap_main (tap_main),
    .tap_post (tap_post),
    .dac_code (dac_code),
    .dac_vld  (dac_vld)
  );

endmodule

// File: rtl/pam4_ffe_tx_chk.sv
module pam4_ffe_tx_chk #(
  parameter int TAP_W = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bit_vld,
  input logic                   pam2_mode,
  input logic [TAP_W-1:0]       tap_pre,
  input logic [TAP_W-1:0]       tap_main,
  input logic [TAP_W-1:0]       tap_post,
  input logic                   sym_vld,
  input logic                   sym_lsb,
  input logic signed [TAP_W+4:0] dac_code,
  input logic                   dac_vld
);

  int bound;
  always_comb bound = 3 * (int'(tap_pre) + int'(tap_main) + int'(tap_post));

  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> (!dac_vld && dac_code == '0));

  a_r1_pair_after_bit: assert property (@(posedge clk) disable iff (rst)
    sym_vld |-> $past(bit_vld));

  a_r4_pam2_lsb_forced: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && $past(pam2_mode)) |-> !sym_lsb);

  a_r5_out_follows_sym: assert property (@(posedge clk) disable iff (rst)
    dac_vld |-> $past(sym_vld));

  a_r8_idle_no_out: assert property (@(posedge clk) disable iff (rst)
    !sym_vld |=> !dac_vld);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    dac_vld |-> (int'(dac_code) <= bound && int'(dac_code) >= -bound));

endmodule

bind pam4_ffe_tx pam4_ffe_tx_chk #(.TAP_W(TAP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_vld   (bit_vld),
  .pam2_mode (pam2_mode),
  .tap_pre   (tap_pre),
  .tap_main  (tap_main),
  .tap_post  (tap_post),
  .sym_vld   (sym_vld),
  .sym_lsb   (sym_lsb),
  .dac_code  (dac_code),
  .dac_vld   (dac_vld)
);

// File: tb/pam4_ffe_tx_tb.sv
`timescale 1ns/1ps
module pam4_ffe_tx_tb;

  localparam int TAP_W = 6;
  localparam int OUT_W = TAP_W + 5;
  localparam int TMAX  = (1 << TAP_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic pam2_mode = 1'b0;
  logic [TAP_W-1:0] tap_pre = '0, tap_main = '0, tap_post = '0;
  logic signed [OUT_W-1:0] dac_code;
  logic dac_vld;

  int n_chk = 0;
  int n_fail = 0;
  int got[$];

  always #4 clk = ~clk;

  pam4_ffe_tx #(.TAP_W(TAP_W)) u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .pam2_mode(pam2_mode), .tap_pre(tap_pre), .tap_main(tap_main),
    .tap_post(tap_post), .dac_code(dac_code), .dac_vld(dac_vld)
  );

  always @(negedge clk) if (!rst && dac_vld) got.push_back(int'(dac_code));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    got.delete();
  endtask

  task automatic send_bit(bit b, int gap);
    @(negedge clk);
    bit_in = b;
    bit_vld = 1'b1;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in = 1'($urandom);
    end
  endtask

  // R2 table: -3 -> 00, -1 -> 01, +1 -> 11, +3 -> 10 (MSB sent first, R1)
  task automatic send_level(int lv, int gap, int mid_gap);
    bit m, l;
    case (lv)
      -3: begin m = 0; l = 0; end
      -1: begin m = 0; l = 1; end
       1: begin m = 1; l = 1; end
      default: begin m = 1; l = 0; end
    endcase
    send_bit(m, mid_gap);
    send_bit(l, gap);
  endtask

  task automatic drain();
    @(negedge clk);
    bit_vld = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int model(int nxt, int cur, int prv);
    return int'(tap_main) * cur - int'(tap_pre) * nxt - int'(tap_post) * prv;
  endfunction

  task automatic compare(string req, int lv[$]);
    check(got.size() == lv.size() - 2, {req, " output count"}, got.size(), lv.size() - 2);
    for (int j = 1; j + 1 < lv.size() && j - 1 < got.size(); j++)
      check(got[j-1] == model(lv[j+1], lv[j], lv[j-1]), req, got[j-1],
            model(lv[j+1], lv[j], lv[j-1]));
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(dac_vld == 1'b0, "R7 vld after reset", dac_vld, 0);
    check(dac_code == '0, "R7 code after reset", dac_code, 0);
    tap_main = 6'd5;
    send_level(3, 0, 0); send_level(1, 0, 0); send_level(-1, 0, 0);
    @(negedge clk); bit_vld = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(dac_vld == 1'b0 && dac_code == '0, "R7 reset clears output", dac_code, 0);
    rst = 1'b0;
    got.delete();
    send_level(3, 0, 0); send_level(3, 0, 0);
    drain();
    check(got.size() == 0, "R7 history cleared", got.size(), 0);
  endtask

  task automatic t_identity();
    int lv[$] = '{-3, -1, 1, 3, 1, -1, -3, 3, -3};
    tap_pre = 0; tap_main = 1; tap_post = 0; pam2_mode = 0;
    do_reset();
    foreach (lv[i]) send_level(lv[i], 0, 0);
    drain();
    compare("R2 gray map", lv);
  endtask

  task automatic t_pam4_ffe();
    int lv[$] = '{3, -3, 1, 1, -1, 3, 3, -3, -1, 1, -3, 3};
    tap_pre = 6'd3; tap_main = 6'd20; tap_post = 6'd7; pam2_mode = 0;
    do_reset();
    foreach (lv[i]) send_level(lv[i], 0, 0);
    drain();
    compare("R3 R1 ffe output", lv);
  endtask

  task automatic t_pam2();
    bit bs[$] = '{1, 0, 0, 1, 1, 1, 0, 1, 0, 0};
    int lv[$];
    tap_pre = 6'd2; tap_main = 6'd9; tap_post = 6'd4; pam2_mode = 1;
    do_reset();
    foreach (bs[i]) begin
      send_bit(bs[i], 0);
      lv.push_back(bs[i] ? 3 : -3);
    end
    drain();
    compare("R4 two-level", lv);
    pam2_mode = 0;
  endtask

  task automatic t_gaps();
    int lv[$] = '{-1, 3, -3, 1, 3, -1, 1, -3};
    tap_pre = 6'd5; tap_main = 6'd31; tap_post = 6'd11; pam2_mode = 0;
    do_reset();
    foreach (lv[i]) send_level(lv[i], i % 3, (i + 1) % 2);
    drain();
    compare("R8 idle gaps", lv);
  endtask

  task automatic t_latency();
    tap_pre = 6'd1; tap_main = 6'd4; tap_post = 6'd2; pam2_mode = 0;
    do_reset();
    send_level(1, 0, 0); send_level(-3, 0, 0); send_level(3, 0, 0);
    @(negedge clk);
    bit_vld = 1'b0;
    check(dac_vld == 1'b0, "R5 not yet valid", dac_vld, 0);
    @(negedge clk);
    check(dac_vld == 1'b1, "R5 first valid edge", dac_vld, 1);
    check(int'(dac_code) == 4 * -3 - 1 * 3 - 2 * 1, "R5 first value", dac_code, -17);
    @(negedge clk);
    check(dac_vld == 1'b0, "R5 single pulse", dac_vld, 0);
    check(got.size() == 1, "R5 pulse count", got.size(), 1);
  endtask

  task automatic t_extremes();
    int lvls[4] = '{-3, -1, 1, 3};
    tap_pre = TMAX; tap_main = TMAX; tap_post = TMAX; pam2_mode = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          do_reset();
          send_level(lvls[a], 0, 0); send_level(lvls[b], 0, 0); send_level(lvls[c], 0, 0);
          drain();
          check(got.size() == 1 && got[0] == model(lvls[c], lvls[b], lvls[a]),
                "R6 full-scale combination", got.size() > 0 ? got[0] : -9999,
                model(lvls[c], lvls[b], lvls[a]));
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_identity();
    t_pam4_ffe();
    t_pam2();
    t_gaps();
    t_latency();
    t_extremes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule